// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that sits on a small register bus inside a chipset. Software programs a starting value, clears the halt bit, and then has to keep writing a reload code to the count register. Each tick-enable pulse takes one from the live count. When a tick arrives while the count already reads zero, the count has expired. The count then restarts from the programmed starting value.

Expiries escalate in two stages. The first expiry only raises a sticky timeout flag. If a second expiry arrives while that flag is still set, the block raises a sticky second-timeout flag and drives a one-cycle system reset pulse. A strap input can veto that pulse while still letting the flag record the event. Every status flag stays set until software writes a 1 to its bit. Clearing the timeout flag in time means two more full countdowns are needed before any reset.

Register word addresses: 0 is the count/reload register, 1 is the starting value, 2 is control, 3 is status one and 4 is status two. Unmapped addresses read as zero. Writes take effect on the rising clock edge while `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset the block is halted (control bit 11 reads 1), the starting value and the count both read 4, and both status registers read 0.
- R2: Writing 0x01 into the low byte of address 0, with byte enable 0 set, loads the count with the starting value on the next edge. Any other low-byte value, or a write without byte enable 0, leaves the count unchanged. Reading address 0 returns the count in bits 9:0, with zeros above.
- R3: The starting value is a 10-bit field in bits 9:0 of address 1. Bits 15:10 always read 0. Byte enable 0 selects bits 7:0 of a write and byte enable 1 selects bits 15:8. Bytes that are not enabled keep their old value.
- R4: A write that would leave the starting value field below 4 is dropped whole, and the previous value is kept.
- R5: Control bit 11 is the halt bit, written through byte enable 1 and read back as written. While it is 1, ticks do not change the count.
- R6: While running, each tick lowers the count by one. A tick at count zero is an expiry and reloads the starting value. A reload leaves the count at the starting value P, and the next expiry comes on tick P+1.
- R7: An expiry while status-one bit 3 is clear sets that bit and gives no reset pulse.
- R8: An expiry while status-one bit 3 is set does three things: it sets status-two bit 1, it sets the boot flag in status-two bit 2, and it drives `sys_rst_pulse` high for exactly the one cycle after that edge.
- R9: While `no_reboot` is high, such a second expiry still sets status-two bit 1. It drives no reset pulse and leaves the boot flag untouched.
- R10: Status-one bit 3, status-two bit 1 and status-two bit 2 clear only when written with 1 under byte enable 0. Writing 0 has no effect. A flag set by an expiry survives a clear in the same cycle.
- R11: Clearing status-one bit 3 after a first expiry means the next expiry counts as a first one again. No second timeout occurs until one more expiry after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle count-rate pulse |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| no_reboot | input | 1 | Vetoes the reset pulse |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its defaults: a 10-bit count, a minimum starting value of 4 and a 3-bit address. It sweeps every starting value from 0 to 15 and checks which of them are accepted. It then runs full countdowns for starting values 4 through 9, which brings the exact expiry tick, the first and second stage, clearing between stages, and both settings of `no_reboot` within a few thousand cycles. Byte-enable merging, rejected reload codes and halting are each covered by short directed sequences.

// File: rtl/wdt_pkg.sv
// Package: shared register map, bit positions and decoded write strobes
// for the two-stage watchdog. Assumes a 16-bit data bus with two byte lanes.
package wdt_pkg;

    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;

    // Word addresses of the registers.
    typedef enum logic [2:0] {
        A_COUNT  = 3'd0,
        A_PRESET = 3'd1,
        A_CTRL   = 3'd2,
        A_STS1   = 3'd3,
        A_STS2   = 3'd4
    } reg_addr_e;

    // Bit positions that software decodes.
    localparam int HALT_BIT = 11;
    localparam int TO_BIT   = 3;
    localparam int SEC_BIT  = 1;
    localparam int BOOT_BIT = 2;

    // Low-byte code that reloads the count.
    localparam logic [7:0] KICK_CODE = 8'h01;

    // One strobe per register write.
    typedef struct packed {
        logic kick;
        logic preset_wr;
        logic ctrl_wr;
        logic sts1_wr;
        logic sts2_wr;
    } wr_dec_t;

endpackage

// File: rtl/wdt_decode.sv
// Module: wdt_decode
// Turns a bus write into per-register strobes. The kick strobe fires only
// when the low byte is enabled and carries the reload code.
// Assumes the address is a word address no narrower than the map.
module wdt_decode
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              be_lo,
    input  logic [7:0]        wdata_lo,
    output wr_dec_t           dec
);

    // Decode address and write strobe into one-hot register strobes.
    always_comb begin
        dec           = '0;
        dec.kick      = bus_wr && (bus_addr == ADDR_W'(A_COUNT)) && be_lo
                        && (wdata_lo == KICK_CODE);
        dec.preset_wr = bus_wr && (bus_addr == ADDR_W'(A_PRESET));
        dec.ctrl_wr   = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
        dec.sts1_wr   = bus_wr && (bus_addr == ADDR_W'(A_STS1));
        dec.sts2_wr   = bus_wr && (bus_addr == ADDR_W'(A_STS2));
    end

endmodule

// File: rtl/wdt_cfg.sv
// Module: wdt_cfg
// Holds the starting value and the halt bit. Merges written bytes with
// the old value and drops any write whose result would fall below
// MIN_PRESET. Assumes CNT_W <= 16 and a synchronous active-low reset.
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int MIN_PRESET = 4,
    parameter int RST_PRESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_wr,
    input  logic              ctrl_wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  preset,
    output logic              halt
);

    localparam int HALT_LANE = HALT_BIT / 8;

    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] merged;
    logic [CNT_W-1:0]  cand;
    logic              cand_ok;

    assign old_word = {{(DATA_W-CNT_W){1'b0}}, preset};

    // One mux per byte lane: enabled lanes take the bus, others keep old.
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : old_word[b*8 +: 8];
    end

    assign cand    = merged[CNT_W-1:0];
    assign cand_ok = (cand >= CNT_W'(MIN_PRESET));

    // Starting value register: accept only legal values.
    always_ff @(posedge clk) begin
        if (!rst_n)
            preset <= CNT_W'(RST_PRESET);
        else if (preset_wr && cand_ok)
            preset <= cand;
    end

    // Halt bit: written through its byte lane, comes up halted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt <= 1'b1;
        else if (ctrl_wr && be[HALT_LANE])
            halt <= wdata[HALT_BIT];
    end

    // R4
    preset_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset >= CNT_W'(MIN_PRESET));

    // R4
    illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_wr && !cand_ok) |=> $stable(preset));

    // R5
    halt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && be[HALT_LANE]) |=> (halt == $past(wdata[HALT_BIT])));

endmodule

// File: rtl/wdt_countdown.sv
// Module: wdt_countdown
// The live count. A kick reloads it from the starting value. Otherwise a
// tick while running lowers it by one, and a tick at zero flags an expiry
// and reloads. The kick takes priority over a tick in the same cycle.
module wdt_countdown #(
    parameter int CNT_W      = 10,
    parameter int RST_PRESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             kick,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic step;

    assign step   = tick && !halt && !kick;
    assign expire = step && (count == '0);

    // Count register: reload on kick or expiry, else decrement per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CNT_W'(RST_PRESET);
        else if (kick || expire)
            count <= preset;
        else if (step)
            count <= count - CNT_W'(1);
    end

    // R2
    kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == $past(preset)));

    // R5
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(count));

    // R6
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(preset)));

    // R6
    tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count != '0) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/wdt_stage.sv
// Module: wdt_stage
// Two-stage escalation and sticky status. An expiry with the timeout flag
// clear sets the flag. An expiry with it set records a second timeout and,
// unless vetoed, pulses the reset and sets the boot flag. Each expiry is
// judged against the flag value held before the cycle's bus write.
module wdt_stage
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       no_reboot,
    input  logic       sts1_wr,
    input  logic       sts2_wr,
    input  logic       be_lo,
    input  logic [7:0] wdata_lo,
    output logic       to_flag,
    output logic       sec_flag,
    output logic       boot_flag,
    output logic       sys_rst
);

    logic first_hit;
    logic second_hit;
    logic clr_to;
    logic clr_sec;
    logic clr_boot;

    assign first_hit  = expire && !to_flag;
    assign second_hit = expire && to_flag;
    assign clr_to     = sts1_wr && be_lo && wdata_lo[TO_BIT];
    assign clr_sec    = sts2_wr && be_lo && wdata_lo[SEC_BIT];
    assign clr_boot   = sts2_wr && be_lo && wdata_lo[BOOT_BIT];

    // First-stage flag: set by a first expiry, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) to_flag <= 1'b0;
        else        to_flag <= first_hit || (to_flag && !clr_to);
    end

    // Second-stage flag: set by a second expiry, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_flag <= 1'b0;
        else        sec_flag <= second_hit || (sec_flag && !clr_sec);
    end

    // Boot flag: set when a reset is actually requested.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_flag <= 1'b0;
        else        boot_flag <= (second_hit && !no_reboot) || (boot_flag && !clr_boot);
    end

    // Reset pulse: one cycle after an unvetoed second expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst <= 1'b0;
        else        sys_rst <= second_hit && !no_reboot;
    end

    // R7
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !to_flag) |=> (to_flag && !sys_rst));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    // R8
    pulse_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (sec_flag && boot_flag));

    // R9
    veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && to_flag && no_reboot) |=> (sec_flag && !sys_rst));

    // R10
    sticky_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !(sts1_wr && be_lo && wdata_lo[TO_BIT])) |=> to_flag);

endmodule

// File: rtl/two_stage_wdt.sv
// Module: two_stage_wdt
// Top of the two-stage watchdog: bus decode, configuration, countdown and
// escalation, plus the combinational read mux. Assumes word addresses,
// a 16-bit bus and a synchronous active-low reset.
module two_stage_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 10,
    parameter int MIN_PRESET = 4,
    parameter int RST_PRESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              no_reboot,
    output logic              sys_rst_pulse
);

    localparam int PAD_W = DATA_W - CNT_W;

    wr_dec_t          dec;
    logic [CNT_W-1:0] preset;
    logic             halt;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             to_flag;
    logic             sec_flag;
    logic             boot_flag;

    wdt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .be_lo    (bus_be[0]),
        .wdata_lo (bus_wdata[7:0]),
        .dec      (dec)
    );

    wdt_cfg #(
        .CNT_W      (CNT_W),
        .MIN_PRESET (MIN_PRESET),
        .RST_PRESET (RST_PRESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_wr (dec.preset_wr),
        .ctrl_wr   (dec.ctrl_wr),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .preset    (preset),
        .halt      (halt)
    );

    wdt_countdown #(
        .CNT_W      (CNT_W),
        .RST_PRESET (RST_PRESET)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .halt   (halt),
        .kick   (dec.kick),
        .preset (preset),
        .count  (count),
        .expire (expire)
    );

    wdt_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .no_reboot (no_reboot),
        .sts1_wr   (dec.sts1_wr),
        .sts2_wr   (dec.sts2_wr),
        .be_lo     (bus_be[0]),
        .wdata_lo  (bus_wdata[7:0]),
        .to_flag   (to_flag),
        .sec_flag  (sec_flag),
        .boot_flag (boot_flag),
        .sys_rst   (sys_rst_pulse)
    );

    // Read mux: place each register's fields at their bit positions.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_COUNT))
            bus_rdata = {{PAD_W{1'b0}}, count};
        else if (bus_addr == ADDR_W'(A_PRESET))
            bus_rdata = {{PAD_W{1'b0}}, preset};
        else if (bus_addr == ADDR_W'(A_CTRL))
            bus_rdata[HALT_BIT] = halt;
        else if (bus_addr == ADDR_W'(A_STS1))
            bus_rdata[TO_BIT] = to_flag;
        else if (bus_addr == ADDR_W'(A_STS2)) begin
            bus_rdata[SEC_BIT]  = sec_flag;
            bus_rdata[BOOT_BIT] = boot_flag;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (halt && !to_flag && !sec_flag && !boot_flag && !sys_rst_pulse));

endmodule

// File: tb/two_stage_wdt_test.sv
module two_stage_wdt_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        no_reboot = 1'b0;
    logic        sys_rst_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    localparam logic [2:0] AC = 3'd0, AP = 3'd1, AK = 3'd2, AS1 = 3'd3, AS2 = 3'd4;

    two_stage_wdt uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .no_reboot(no_reboot), .sys_rst_pulse(sys_rst_pulse)
    );

    always #5 clk = ~clk;

    // Count reset pulses away from the active edge.
    always @(negedge clk) if (rst_n && sys_rst_pulse) pulses++;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int exp_p;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(AC, v);  check("R1 count", v, 4);
        rd(AP, v);  check("R1 preset", v, 4);
        rd(AK, v);  check("R1 ctrl", v, 16'h0800);
        rd(AS1, v); check("R1 sts1", v, 0);
        rd(AS2, v); check("R1 sts2", v, 0);
        check("R1 pulse", pulses, 0);

        // R4 sweep of starting values 0..15
        exp_p = 4;
        for (int s = 15; s >= 0; s--) begin
            wr(AP, 16'(s), 2'b11);
            if (s >= 4) exp_p = s;
            rd(AP, v); check("R4 preset sweep", v, exp_p);
        end

        // R3 byte lanes and 10-bit field
        wr(AP, 16'hFC05, 2'b11); rd(AP, v); check("R3 upper bits", v, 16'h0005);
        wr(AP, 16'h1234, 2'b01); rd(AP, v); check("R3 low lane", v, 16'h0034);
        wr(AP, 16'h0300, 2'b10); rd(AP, v); check("R3 high lane", v, 16'h0334);
        wr(AP, 16'hFFFF, 2'b11); rd(AP, v); check("R3 full", v, 16'h03FF);
        wr(AP, 16'h0002, 2'b11); rd(AP, v); check("R4 low drop", v, 16'h03FF);

        // R6..R11 full countdowns for P = 4..9
        for (int p = 4; p <= 9; p++) begin
            no_reboot = p[0];
            wr(AK, 16'h0800, 2'b10);
            wr(AP, 16'(p), 2'b11);
            wr(AS1, 16'h0008, 2'b01);
            wr(AS2, 16'h0006, 2'b01);
            wr(AC, 16'h0001, 2'b01);
            rd(AC, v); check("R2 kick", v, p);
            wr(AK, 16'h0000, 2'b10);
            rd(AK, v); check("R5 run", v, 0);
            tick(p);
            rd(AC, v); check("R6 count zero", v, 0);
            p0 = pulses;
            tick(1);
            rd(AC, v);  check("R6 reload", v, p);
            rd(AS1, v); check("R7 first flag", v, 8);
            rd(AS2, v); check("R7 no second", v, 0);
            check("R7 no pulse", pulses, p0);
            wr(AS1, 16'h0000, 2'b01);
            rd(AS1, v); check("R10 zero write", v, 8);
            wr(AS1, 16'h0008, 2'b01);
            rd(AS1, v); check("R10 clear", v, 0);
            tick(p + 1);
            rd(AS1, v); check("R11 first again", v, 8);
            rd(AS2, v); check("R11 no second", v, 0);
            check("R11 no pulse", pulses, p0);
            tick(p + 1);
            rd(AS2, v);
            if (p[0]) begin
                check("R9 second flag", v, 2);
                check("R9 vetoed", pulses, p0);
            end else begin
                check("R8 second+boot", v, 6);
                check("R8 one pulse", pulses, p0 + 1);
            end
            rd(AC, v);  check("R6 reload after second", v, p);
            rd(AS1, v); check("R8 flag kept", v, 8);
            wr(AS2, 16'h0000, 2'b01);
            rd(AS2, v); check("R10 zero write sts2", v, p[0] ? 2 : 6);
            wr(AS2, 16'h0004, 2'b01);
            rd(AS2, v); check("R10 boot clear", v, 2);
            wr(AS2, 16'h0002, 2'b10);
            rd(AS2, v); check("R10 lane needed", v, 2);
            wr(AS2, 16'h0002, 2'b01);
            rd(AS2, v); check("R10 second clear", v, 0);
        end
        no_reboot = 1'b0;

        // R2 reload codes
        wr(AS1, 16'h0008, 2'b01);
        wr(AP, 16'd20, 2'b11);
        wr(AC, 16'h0001, 2'b01);
        tick(3);
        rd(AC, v); check("R6 mid count", v, 17);
        wr(AC, 16'h0002, 2'b01); rd(AC, v); check("R2 wrong code", v, 17);
        wr(AC, 16'h0101, 2'b10); rd(AC, v); check("R2 lane off", v, 17);
        wr(AC, 16'h0001, 2'b01); rd(AC, v); check("R2 reload", v, 20);

        // R5 halt
        wr(AK, 16'h0800, 2'b10);
        rd(AK, v); check("R5 readback", v, 16'h0800);
        tick(5);
        rd(AC, v); check("R5 frozen", v, 20);
        wr(AK, 16'h0000, 2'b01);
        rd(AK, v); check("R5 lane off", v, 16'h0800);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule